// File: doc/BRIEF.md
# Bus-Sharing Access Counter Arbiter

This block shares one memory bus between a host processor and a block-transfer engine that runs in a cooperative (non-exclusive) mode. Once the engine asks to start, the bus alternates between the two owners. Each owner keeps the bus for a fixed quota of memory accesses, 64 by default. The quota is measured in accesses, not in clock cycles. An access is detected as the rising edge of the address strobe that belongs to the current owner. While the processor holds the bus, that is the processor strobe. While the engine holds the bus, that is the engine's own strobe.

All state advances only on clock-enable pulses. These pulses come from a faster system clock, typically one pulse every four clocks. Inputs are sampled on those enabled edges only. A handover waits until the current owner's strobe is inactive, so an access that is in progress is never cut off. When the engine reports that it is done, the processor keeps the bus until a new start request arrives.

Both strobes are active high in this block.

Top module: `bus_share_arbiter`

## Requirements
- R1: After reset the processor owns the bus: `bus_grant`=0, `bus_req`=0 and `access_cnt`=0.
- R2: In idle, `start_req` sampled high on an enabled edge raises `bus_req` after that edge. `bus_grant` rises only after an enabled edge at which `cpu_strobe` is sampled low. At that point `bus_req` drops and `access_cnt` is 0.
- R3: The counter advances by exactly 1 for each 0-to-1 transition of the owner's strobe between two consecutive enabled edges. A strobe held high over many enabled edges counts once. A pulse that starts and ends between enabled edges is not counted.
- R4: While the engine owns the bus (`bus_grant`=1), only `eng_strobe` is counted and `cpu_strobe` has no effect on `access_cnt`.
- R5: While the processor owns the bus in an active share (`bus_grant`=0 after a grant), only `cpu_strobe` is counted and `eng_strobe` has no effect.
- R6: Once the engine's count reaches QUOTA, `bus_grant` falls at the first enabled edge that samples `eng_strobe` low. `access_cnt` returns to 0 at that edge.
- R7: Once the processor's count reaches QUOTA, `bus_req` is 1. `bus_grant` rises again at the first enabled edge that samples `cpu_strobe` low, with `access_cnt` cleared.
- R8: `xfer_done` sampled high on an enabled edge ends the share. After it, `bus_grant`=0, `bus_req`=0 and `access_cnt`=0, and processor accesses are no longer counted.
- R9: `access_cnt` never exceeds QUOTA, even while the last strobe stays high.
- R10: `start_req` has no effect while a share is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; state advances only on enabled edges |
| start_req | input | 1 | Engine asks to begin a shared transfer |
| xfer_done | input | 1 | Engine reports the transfer is finished |
| cpu_strobe | input | 1 | Processor address strobe, active high |
| eng_strobe | input | 1 | Engine address strobe, active high |
| bus_req | output | 1 | Engine is waiting to take the bus |
| bus_grant | output | 1 | Engine currently owns the bus (0: processor owns it) |
| access_cnt | output | CNT_W | Accesses counted in the current ownership slot |

## Verification
Every result is registered once at the enabled edge that samples its cause, and becomes visible right after that edge. The one exception is `bus_req` at a full processor quota: it follows the counter combinationally, so it shows on the same enabled edge that counts the 64th access. The bench drives inputs between edges and advances by whole enabled edges. It samples one time unit after the edge that is due to update, and computes the expected count as the number of strobe rises it has issued. Pulses placed entirely between enabled edges, and strobes held across many enabled edges, check that nothing is counted early or twice.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_REQ  = 2'd1,
    SH_ENG  = 2'd2,
    SH_CPU  = 2'd3
  } share_state_t;

  // inactive-to-active transition between two enabled samples
  function automatic logic strobe_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic quota_met(input int unsigned cnt, input int unsigned quota);
    return cnt >= quota;
  endfunction

  function automatic logic slot_active(input share_state_t st);
    return (st == SH_ENG) || (st == SH_CPU);
  endfunction

endpackage

// File: rtl/bsa_strobe_edge.sv
module bsa_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic cur,
  input  logic reload,
  input  logic reload_val,
  output logic rise
);
  import bsa_pkg::*;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (ce)     prev_q <= reload ? reload_val : cur;
  end

  assign rise = strobe_rise(cur, prev_q);

endmodule

// File: rtl/bsa_share_count.sv
module bsa_share_count #(
  parameter int unsigned QUOTA = 64,
  parameter int unsigned CNT_W = $clog2(QUOTA + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  import bsa_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign full = quota_met(int'(cnt_q), QUOTA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ce && clear)    cnt_q <= '0;
    else if (ce && inc && !full) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= QUOTA);

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

  p_hold_off_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ce) |-> $stable(cnt_q));

endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter #(
  parameter int unsigned QUOTA = 64,
  parameter int unsigned CNT_W = $clog2(QUOTA + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             start_req,
  input  logic             xfer_done,
  input  logic             cpu_strobe,
  input  logic             eng_strobe,
  output logic             bus_req,
  output logic             bus_grant,
  output logic [CNT_W-1:0] access_cnt
);
  import bsa_pkg::*;

  share_state_t state_q, state_d;
  logic sel_strobe, new_strobe, strobe_rise_w, quota_full, switch_w, count_inc;

  assign sel_strobe = (state_q == SH_ENG) ? eng_strobe : cpu_strobe;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SH_IDLE: if (start_req) state_d = SH_REQ;
      SH_REQ:  if (xfer_done) state_d = SH_IDLE;
               else if (!cpu_strobe) state_d = SH_ENG;
      SH_ENG:  if (xfer_done) state_d = SH_IDLE;
               else if (quota_full && !eng_strobe) state_d = SH_CPU;
      SH_CPU:  if (xfer_done) state_d = SH_IDLE;
               else if (quota_full && !cpu_strobe) state_d = SH_ENG;
      default: state_d = SH_IDLE;
    endcase
  end

  assign switch_w   = clk_en && (state_d != state_q);
  assign new_strobe = (state_d == SH_ENG) ? eng_strobe : cpu_strobe;
  assign count_inc  = slot_active(state_q) && strobe_rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SH_IDLE;
    else if (clk_en) state_q <= state_d;
  end

  bsa_strobe_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (clk_en),
    .cur        (sel_strobe),
    .reload     (switch_w),
    .reload_val (new_strobe),
    .rise       (strobe_rise_w)
  );

  bsa_share_count #(.QUOTA(QUOTA), .CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (clk_en),
    .clear (switch_w),
    .inc   (count_inc),
    .cnt   (access_cnt),
    .full  (quota_full)
  );

  assign bus_grant = (state_q == SH_ENG);
  assign bus_req   = (state_q == SH_REQ) || ((state_q == SH_CPU) && quota_full);

  p_grant_on_idle_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(clk_en && !cpu_strobe));

  p_release_on_idle_eng_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |-> $past(clk_en && (!eng_strobe || xfer_done)));

  p_req_grant_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_grant));

  p_idle_no_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_IDLE) |-> (access_cnt == '0));

endmodule

// File: tb/bus_share_arbiter_bench.sv
module bus_share_arbiter_bench;
  localparam int Q = 64;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic start_req = 1'b0, xfer_done = 1'b0, cpu_strobe = 1'b0, eng_strobe = 1'b0;
  logic bus_req, bus_grant;
  logic [6:0] access_cnt;
  int checks = 0, failures = 0;
  int div = 0;
  bit finished = 0;

  bus_share_arbiter u_bus_share_arbiter (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start_req(start_req),
    .xfer_done(xfer_done), .cpu_strobe(cpu_strobe), .eng_strobe(eng_strobe),
    .bus_req(bus_req), .bus_grant(bus_grant), .access_cnt(access_cnt)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    div = (div + 1) % 4;
    clk_en <= (div == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!clk_en);
      #1;
    end
  endtask

  task automatic pulse_eng(); eng_strobe = 1; step(1); eng_strobe = 0; step(1); endtask
  task automatic pulse_cpu(); cpu_strobe = 1; step(1); cpu_strobe = 0; step(1); endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 grant", bus_grant, 0); chk("R1 req", bus_req, 0); chk("R1 cnt", access_cnt, 0);
    step(1);
    pulse_cpu(); pulse_cpu();
    chk("R8 idle cpu not counted", access_cnt, 0);

    cpu_strobe = 1; start_req = 1; step(1); start_req = 0;
    chk("R2 req after start", bus_req, 1); chk("R2 no grant busy", bus_grant, 0);
    step(2);
    chk("R2 wait on cpu strobe", bus_grant, 0);
    cpu_strobe = 0; step(1);
    chk("R2 grant", bus_grant, 1); chk("R2 req drop", bus_req, 0); chk("R2 cnt", access_cnt, 0);

    pulse_cpu();
    chk("R4 cpu ignored", access_cnt, 0);
    eng_strobe = 1; step(5); eng_strobe = 0; step(1);
    chk("R3 long strobe once", access_cnt, 1);
    eng_strobe = 1; @(posedge clk); #1; eng_strobe = 0; step(1);
    chk("R3 between enables", access_cnt, 1);
    start_req = 1; step(1); start_req = 0;
    chk("R10 start ignored grant", bus_grant, 1); chk("R10 start ignored cnt", access_cnt, 1);

    for (int i = 2; i < Q; i++) begin
      pulse_eng();
      chk("R3 eng count", access_cnt, i);
    end
    eng_strobe = 1; step(1);
    chk("R6 full cnt", access_cnt, Q); chk("R6 held", bus_grant, 1);
    step(2);
    chk("R9 no overflow", access_cnt, Q); chk("R6 strobe high keeps", bus_grant, 1);
    eng_strobe = 0; step(1);
    chk("R6 release", bus_grant, 0); chk("R6 cnt clear", access_cnt, 0); chk("R6 req", bus_req, 0);

    pulse_eng();
    chk("R5 eng ignored", access_cnt, 0);
    for (int i = 1; i < Q; i++) begin
      pulse_cpu();
      chk("R5 cpu count", access_cnt, i);
    end
    cpu_strobe = 1; step(1);
    chk("R7 full cnt", access_cnt, Q); chk("R7 req", bus_req, 1); chk("R7 no grant", bus_grant, 0);
    cpu_strobe = 0; step(1);
    chk("R7 grant back", bus_grant, 1); chk("R7 cnt clear", access_cnt, 0); chk("R7 req drop", bus_req, 0);

    pulse_eng();
    xfer_done = 1; step(1); xfer_done = 0;
    chk("R8 grant", bus_grant, 0); chk("R8 req", bus_req, 0); chk("R8 cnt", access_cnt, 0);
    pulse_cpu(); pulse_eng();
    chk("R8 no count after done", access_cnt, 0); chk("R8 stays cpu", bus_grant, 0);

    start_req = 1; step(1); start_req = 0;
    chk("R2 restart req", bus_req, 1);
    step(1);
    chk("R2 restart grant", bus_grant, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule